// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Add-One Converters

This block adds two unsigned operands and a carry-in in a single combinational pass, producing a sum of the same width and a carry-out. The bit range is cut into groups whose widths grow toward the top, so later groups have more time to finish before the carry from below reaches them. The bottom group is a plain 2-bit ripple adder driven by the external carry-in.

Every higher group computes its result once, assuming no incoming carry. It derives the "carry arrived" result by adding one to that first result with a small increment network, and does not use a second adder. The real carry coming up from the group below then selects between the two results and passes its own carry on to the next group.

The width is chosen by a parameter with two supported values. A 32-bit instance uses groups of 2, 2, 3, 4, 6, 7 and 8 bits, counted from the least significant end. A 64-bit instance continues that series with 9, 11 and 12 bits.

Top module: `csla_sqrt`

## Requirements
- R1: For every operand pair and carry-in, {cout, sum} equals a + b + cin computed at WIDTH+1 bits.
- R2: The bit range is split into groups of 2, 2, 3, 4, 6, 7, 8 bits (WIDTH=32) or 2, 2, 3, 4, 6, 7, 8, 9, 11, 12 bits (WIDTH=64), starting at bit 0. A carry that enters at any group boundary propagates correctly into the group above.
- R3: The lowest group is a 2-bit ripple adder fed by cin. The carry it hands up equals bit 2 of a[1:0] + b[1:0] + cin.
- R4: In each higher group, the carry-in-1 candidate, taken as the group's carry bit followed by its sum bits, is exactly one more than the carry-in-0 candidate over W+1 bits.
- R5: Each higher group's slice of sum equals the group's slice of a plus its slice of b plus the carry arriving from the group below.
- R6: The carry handed out of each group equals the carry out of the addition of all bits below that group's top, together with cin.
- R7: cout is the carry selected by the most significant group. It is 1 exactly when a + b + cin overflows WIDTH bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The hardest case to reach from the ports is a carry that is born exactly at one group boundary and then has to pass through the select of every group above it. Random operands almost never produce a long run of propagate bits that lines up with a boundary. The bench builds such operands on purpose. For each boundary position it takes a run of ones below the boundary plus a carry-in, and it also uses an all-ones operand with carry-in, so that the carry travels through every selection stage. Exhaustive low-bit patterns cover the ripple group, and alternating-bit operands cover mixed propagate and generate.

// File: rtl/csla_pkg.sv
package csla_pkg;

    // Width of group idx, least significant group first.
    function automatic int grp_w(input int idx);
        case (idx)
            0: return 2;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 6;
            5: return 7;
            6: return 8;
            7: return 9;
            8: return 11;
            default: return 12;
        endcase
    endfunction

    // Number of groups for a supported total width.
    function automatic int grp_n(input int width);
        return (width > 32) ? 10 : 7;
    endfunction

    // Lowest bit position of group idx.
    function automatic int grp_lsb(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc += grp_w(k);
        return acc;
    endfunction

endpackage

// File: rtl/csla_rca.sv
module csla_rca #(
    parameter int N = 4
) (
    input  logic [N-1:0] op_x,
    input  logic [N-1:0] op_y,
    input  logic         c_in,
    output logic [N-1:0] s_out,
    output logic         c_out
);
    logic [N:0] chain;

    assign chain[0] = c_in;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign s_out[i]   = op_x[i] ^ op_y[i] ^ chain[i];
        assign chain[i+1] = (op_x[i] & op_y[i]) | (chain[i] & (op_x[i] ^ op_y[i]));
    end

    assign c_out = chain[N];
endmodule

// File: rtl/csla_excess1.sv
module csla_excess1 #(
    parameter int N = 5
) (
    input  logic [N-1:0] src,
    output logic [N-1:0] dst
);
    // ones_below[i] is high when every bit under position i is one.
    logic [N:0] ones_below;

    assign ones_below[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign ones_below[i+1] = ones_below[i] & src[i];
        assign dst[i]          = src[i] ^ ones_below[i];
    end
endmodule

// File: rtl/csla_group.sv
module csla_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] ga,
    input  logic [W-1:0] gb,
    input  logic         sel,
    output logic [W-1:0] gsum,
    output logic         gcarry,
    output logic [W-1:0] zero_sum,
    output logic         zero_c,
    output logic [W-1:0] one_sum,
    output logic         one_c
);
    csla_rca #(.N(W)) u_rca (
        .op_x  (ga),
        .op_y  (gb),
        .c_in  (1'b0),
        .s_out (zero_sum),
        .c_out (zero_c)
    );

    csla_excess1 #(.N(W + 1)) u_inc (
        .src ({zero_c, zero_sum}),
        .dst ({one_c, one_sum})
    );

    always_comb begin
        if (sel) begin
            gsum   = one_sum;
            gcarry = one_c;
        end else begin
            gsum   = zero_sum;
            gcarry = zero_c;
        end
    end
endmodule

// File: rtl/csla_sqrt.sv
module csla_sqrt #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    import csla_pkg::*;

    localparam int NG = grp_n(WIDTH);

    // grp_c[g] is the carry entering group g; grp_c[NG] leaves the adder.
    logic [NG:0]      grp_c;
    logic [WIDTH-1:2] z_sum;
    logic [WIDTH-1:2] o_sum;
    logic [NG-1:1]    z_c;
    logic [NG-1:1]    o_c;

    assign grp_c[0] = cin;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int LSB = grp_lsb(g);
        localparam int W   = grp_w(g);
        if (g == 0) begin : g_ripple
            csla_rca #(.N(W)) u_rca (
                .op_x  (a[LSB +: W]),
                .op_y  (b[LSB +: W]),
                .c_in  (grp_c[0]),
                .s_out (sum[LSB +: W]),
                .c_out (grp_c[1])
            );
        end else begin : g_select
            csla_group #(.W(W)) u_grp (
                .ga       (a[LSB +: W]),
                .gb       (b[LSB +: W]),
                .sel      (grp_c[g]),
                .gsum     (sum[LSB +: W]),
                .gcarry   (grp_c[g+1]),
                .zero_sum (z_sum[LSB +: W]),
                .zero_c   (z_c[g]),
                .one_sum  (o_sum[LSB +: W]),
                .one_c    (o_c[g])
            );
        end
    end

    assign cout = grp_c[NG];
endmodule

module csla_sqrt_chk #(
    parameter int WIDTH = 64
) (
    input logic [WIDTH-1:0]                 a,
    input logic [WIDTH-1:0]                 b,
    input logic                             cin,
    input logic [WIDTH-1:0]                 sum,
    input logic                             cout,
    input logic [csla_pkg::grp_n(WIDTH):0]  grp_c,
    input logic [WIDTH-1:2]                 z_sum,
    input logic [WIDTH-1:2]                 o_sum,
    input logic [csla_pkg::grp_n(WIDTH)-1:1] z_c,
    input logic [csla_pkg::grp_n(WIDTH)-1:1] o_c
);
    import csla_pkg::*;

    localparam int NG = grp_n(WIDTH);

    logic [WIDTH:0] full_ref;
    logic [2:0]     low_ref;

    assign full_ref = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    assign low_ref  = {1'b0, a[1:0]} + {1'b0, b[1:0]} + {2'b00, cin};

    always_comb begin
        p_total_sum_r1: assert ({cout, sum} == full_ref)
            else $error("R1 total sum mismatch");
        p_top_carry_r7: assert (cout == full_ref[WIDTH])
            else $error("R7 carry-out mismatch");
        p_ripple_low_r3: assert ({grp_c[1], sum[1:0]} == low_ref)
            else $error("R3 ripple group mismatch");
    end

    for (genvar g = 1; g < NG; g++) begin : g_chk
        localparam int LSB = grp_lsb(g);
        localparam int W   = grp_w(g);
        localparam int TOP = LSB + W;

        logic [W:0]   one_ref;
        logic [W:0]   slice_ref;
        logic [TOP:0] below_ref;

        assign one_ref   = {z_c[g], z_sum[LSB +: W]} + {{W{1'b0}}, 1'b1};
        assign slice_ref = {1'b0, a[LSB +: W]} + {1'b0, b[LSB +: W]} + {{W{1'b0}}, grp_c[g]};
        assign below_ref = {1'b0, a[TOP-1:0]} + {1'b0, b[TOP-1:0]} + {{TOP{1'b0}}, cin};

        always_comb begin
            p_add_one_r4: assert ({o_c[g], o_sum[LSB +: W]} == one_ref)
                else $error("R4 add-one path mismatch in group %0d", g);
            p_slice_r5: assert (sum[LSB +: W] == slice_ref[W-1:0])
                else $error("R5 group slice mismatch in group %0d", g);
            p_handoff_r6: assert (grp_c[g+1] == below_ref[TOP])
                else $error("R6 carry hand-off mismatch in group %0d", g);
        end
    end
endmodule

bind csla_sqrt csla_sqrt_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_csla_sqrt.sv
module tb_csla_sqrt;
    localparam int CLK_PERIOD = 10;
    localparam int W64 = 64;
    localparam int W32 = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [W64-1:0] a, b, sum;
    logic           cin, cout;
    logic [W32-1:0] a32, b32, sum32;
    logic           cin32, cout32;

    csla_sqrt #(.WIDTH(W64)) dut (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));
    csla_sqrt #(.WIDTH(W32)) dut_w32 (
        .a(a32), .b(b32), .cin(cin32), .sum(sum32), .cout(cout32));

    // Group widths from the requirements, used to place boundaries.
    function automatic int bw(input int i);
        int t[10] = '{2, 2, 3, 4, 6, 7, 8, 9, 11, 12};
        return t[i];
    endfunction

    task automatic apply64(input logic [W64-1:0] xa, input logic [W64-1:0] xb,
                           input logic xc, input string req);
        logic [W64:0] exp;
        @(negedge clk);
        a = xa; b = xb; cin = xc;
        #1;
        exp = {1'b0, xa} + {1'b0, xb} + {{W64{1'b0}}, xc};
        checks++;
        if ({cout, sum} !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, {cout, sum}, exp);
        end
    endtask

    task automatic apply32(input logic [W32-1:0] xa, input logic [W32-1:0] xb,
                           input logic xc, input string req);
        logic [W32:0] exp;
        @(negedge clk);
        a32 = xa; b32 = xb; cin32 = xc;
        #1;
        exp = {1'b0, xa} + {1'b0, xb} + {{W32{1'b0}}, xc};
        checks++;
        if ({cout32, sum32} !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", req, {cout32, sum32}, exp);
        end
    endtask

    task automatic t_idle;
        apply64('0, '0, 1'b0, "R1 idle zero");
        apply32('0, '0, 1'b0, "R1 idle zero w32");
    endtask

    task automatic t_corners;
        apply64('1, '0, 1'b1, "R7 all ones plus cin");
        apply64('1, '1, 1'b1, "R7 all ones both");
        apply64('1, '1, 1'b0, "R1 all ones no cin");
        apply64('0, '0, 1'b1, "R1 zero plus cin");
        apply32('1, '0, 1'b1, "R7 all ones plus cin w32");
        apply32('1, '1, 1'b1, "R7 all ones both w32");
    endtask

    task automatic t_alternating;
        apply64({32{2'b10}}, {32{2'b01}}, 1'b1, "R5 alternating complement");
        apply64({32{2'b10}}, {32{2'b10}}, 1'b0, "R5 alternating same");
        apply64({32{2'b01}}, {32{2'b01}}, 1'b1, "R5 alternating same cin");
        apply32({16{2'b10}}, {16{2'b01}}, 1'b1, "R5 alternating w32");
    endtask

    task automatic t_ripple_low;
        for (int v = 0; v < 32; v++) begin
            logic [W64-1:0] xa, xb;
            xa = '0; xb = '0;
            xa[1:0] = v[1:0];
            xb[1:0] = v[3:2];
            apply64(xa, xb, v[4], "R3 low ripple group");
        end
    endtask

    task automatic t_boundaries;
        int pos;
        pos = 0;
        for (int g = 0; g < 10; g++) begin
            logic [W64-1:0] run;
            pos += bw(g);
            run = (pos >= W64) ? '1 : ((64'd1 << pos) - 64'd1);
            apply64(run, '0, 1'b1, "R6 carry at boundary");
            apply64(run, 64'd1, 1'b0, "R2 boundary by operand");
            apply64(run ^ (64'd1 << (pos - 1)), run, 1'b1, "R4 boundary generate");
            if (pos <= W32) begin
                apply32(run[W32-1:0], '0, 1'b1, "R2 boundary w32");
            end
        end
    endtask

    task automatic t_random;
        for (int i = 0; i < 300; i++) begin
            apply64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
            apply32($urandom, $urandom, 1'($urandom), "R1 random w32");
        end
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        a32 = '0; b32 = '0; cin32 = 1'b0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_corners();
        t_alternating();
        t_ripple_low();
        t_boundaries();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule